// File: doc/BRIEF.md
# Indirect Control and Status Register File

This block is the host-facing register set of a network controller. The host never addresses registers directly. It first writes a register number into a pointer, then reads or writes the selected register through a single data port. The pointer keeps its value, so repeated accesses to one register need only one pointer write.

The block keeps the main command register, which holds the init, start and stop commands, the global interrupt enable, the hardware event flags and two read-only summaries. A separate register holds one interrupt mask bit per event. A bank of configuration registers accepts host access only while the controller is stopped. Events raised elsewhere in the controller reach the block as single-cycle pulses. The block drives the command levels, an error summary and a registered interrupt request.

Register map: pointer 0 is the command register, pointer 1 is the mask register, and pointers 2 to 5 are the four configuration registers. All other pointer values are unimplemented. Command register bits: bit 0 init, bit 1 start, bit 2 stop, bit 3 interrupt enable, bit 6 error summary (read-only), bit 7 unmasked-event pending (read-only). Bits 8 to 11 are the event flags, in this order: memory error, missed frame, transmit started, receive done. The first two event flags count as errors. Mask register bit i masks event flag i.

Top module: `csr_indirect_top`

## Requirements
- R1: A write on the pointer port stores the low 4 bits of the write data as the current register number. The value holds until the next pointer write. A data-port write updates the selected register on the next clock edge. `hostRdata` always shows the selected register, without delay.
- R2: An event flag (command bits 8 to 11) is set by its event pulse and cleared by writing 1 to its bit. Writing 0 leaves the flag unchanged. If an event pulse and a host clear for the same flag arrive in the same cycle, the flag ends up set.
- R3: A command write with bit 2 set clears every event flag, and it also discards any event pulse that arrives in the same cycle.
- R4: A command write with bit 2 set leaves stop = 1, start = 0 and init = 0, whatever bits 0 and 1 hold in the same write.
- R5: A command write with bit 2 clear and bit 0 or bit 1 set clears stop and sets the written start and/or init bits. Writing 0 to start or init has no effect. While stop is 1, event pulses are ignored. `initLevel`, `startLevel` and `stopLevel` show the three command bits.
- R6: Configuration registers (pointers 2 to 5, 16 bits each) take data-port writes only while stop is 1. While running, those writes are discarded.
- R7: While stop is 0, a read of a configuration register returns 0. After a return to stop, the stored value reads back unchanged.
- R8: The error summary (command bit 6 and the `errSummary` output) is the OR of the memory-error and missed-frame flags, and it follows the flags without delay.
- R9: `intReq` is registered. It equals the interrupt enable AND the OR of all flags whose mask bit is 0, and it updates one clock after a flag, mask or enable change. Command bit 7 shows the unmasked OR without the enable gate.
- R10: Pointer values 6 to 15 read as 0, and data writes to them change no register. Command bits 4, 5, 12 to 15 and mask bits 4 to 15 read as 0 whatever was written.
- R11: After reset the command register reads 0x0004 (stopped), the mask and configuration registers read 0, the pointer is 0, and `intReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ptrWr | input | 1 | Strobe: load the register pointer from hostWdata |
| dataWr | input | 1 | Strobe: write hostWdata into the selected register |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Contents of the selected register |
| evtPulse | input | 4 | Event pulses: memory error, missed frame, transmit start, receive done |
| initLevel | output | 1 | Init command level |
| startLevel | output | 1 | Start command level |
| stopLevel | output | 1 | Stop command level |
| errSummary | output | 1 | OR of the error flags |
| intReq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the package defaults: 16-bit data, a 4-bit pointer, four events of which two are errors, and four configuration registers. With these values every unimplemented pointer (6 to 15), every flag and mask pairing, and every configuration slot can be reached within a short random run. Random command words with rare stop bits make stop/start races, same-cycle set and clear of a flag, and locked configuration accesses frequent. Directed cases then pin down the one-cycle lag of the interrupt request and the priority of stop.

// File: rtl/csr_indirect_pkg.sv
package csr_indirect_pkg;
  localparam int DATA_W    = 16;
  localparam int PTR_W     = 4;
  localparam int NUM_EVT   = 4;
  localparam int NUM_ERR   = 2;
  localparam int NUM_CFG   = 4;
  localparam int CFG_IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  localparam logic [PTR_W-1:0] CMD_ADDR  = PTR_W'(0);
  localparam logic [PTR_W-1:0] MASK_ADDR = PTR_W'(1);
  localparam logic [PTR_W-1:0] CFG_FIRST = PTR_W'(2);
  localparam logic [PTR_W-1:0] CFG_LAST  = PTR_W'(2 + NUM_CFG - 1);

  localparam int BIT_INIT    = 0;
  localparam int BIT_START   = 1;
  localparam int BIT_STOP    = 2;
  localparam int BIT_INTEN   = 3;
  localparam int BIT_ERRSUM  = 6;
  localparam int BIT_PEND    = 7;
  localparam int FLAG_LSB    = 8;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CMD  = 2'd1,
    RD_MASK = 2'd2,
    RD_CFG  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                 cmdWr;
    logic                 maskWr;
    logic                 cfgWr;
    rdSel_e               rdSel;
    logic [CFG_IDX_W-1:0] cfgIdx;
  } hostStb_t;
endpackage

// File: rtl/csr_indirect_ctrl.sv
module csr_indirect_ctrl
  import csr_indirect_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ptrWr,
  input  logic             dataWr,
  input  logic [PTR_W-1:0] ptrIn,
  input  logic             stopLevel,
  output hostStb_t         stb
);
  logic [PTR_W-1:0] ptrQ;
  logic [PTR_W-1:0] cfgOff;
  logic             cfgHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ptrQ <= CMD_ADDR;
    else if (ptrWr) ptrQ <= ptrIn;
  end

  assign cfgOff = ptrQ - CFG_FIRST;
  assign cfgHit = (ptrQ >= CFG_FIRST) && (ptrQ <= CFG_LAST);

  always_comb begin
    stb        = '0;
    stb.cfgIdx = cfgOff[CFG_IDX_W-1:0];
    if (ptrQ == CMD_ADDR) begin
      stb.rdSel = RD_CMD;
      stb.cmdWr = dataWr;
    end else if (ptrQ == MASK_ADDR) begin
      stb.rdSel  = RD_MASK;
      stb.maskWr = dataWr;
    end else if (cfgHit) begin
      stb.rdSel = RD_CFG;
      stb.cfgWr = dataWr && stopLevel;
    end else begin
      stb.rdSel = RD_NONE;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ptrWr |=> $stable(ptrQ)); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.cmdWr, stb.maskWr, stb.cfgWr}) <= 1); // R10
endmodule

// File: rtl/csr_indirect_dp.sv
module csr_indirect_dp
  import csr_indirect_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [DATA_W-1:0] rdata,
  output logic              initLevel,
  output logic              startLevel,
  output logic              stopLevel,
  output logic              errSummary,
  output logic              intReq
);
  logic                            stopQ, startQ, initQ, intEnQ, intReqQ;
  logic [NUM_EVT-1:0]              flagsQ, maskQ, clrMask, setMask, liveEvt;
  logic [NUM_CFG-1:0][DATA_W-1:0]  cfgQ;
  logic                            stopCmd, goCmd, anyLive;

  assign stopCmd = stb.cmdWr && wdata[BIT_STOP];
  assign goCmd   = stb.cmdWr && !wdata[BIT_STOP] && (wdata[BIT_START] || wdata[BIT_INIT]);
  assign clrMask = stb.cmdWr ? wdata[FLAG_LSB +: NUM_EVT] : '0;
  assign setMask = stopQ ? '0 : evtPulse;
  assign liveEvt = flagsQ & ~maskQ;
  assign anyLive = |liveEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ   <= 1'b1;
      startQ  <= 1'b0;
      initQ   <= 1'b0;
      intEnQ  <= 1'b0;
      flagsQ  <= '0;
      maskQ   <= '0;
      intReqQ <= 1'b0;
    end else begin
      if (stopCmd) begin
        stopQ  <= 1'b1;
        startQ <= 1'b0;
        initQ  <= 1'b0;
        flagsQ <= '0;
      end else begin
        if (goCmd) begin
          stopQ  <= 1'b0;
          startQ <= startQ | wdata[BIT_START];
          initQ  <= initQ  | wdata[BIT_INIT];
        end
        flagsQ <= (flagsQ & ~clrMask) | setMask;
      end
      if (stb.cmdWr)  intEnQ <= wdata[BIT_INTEN];
      if (stb.maskWr) maskQ  <= wdata[NUM_EVT-1:0];
      intReqQ <= intEnQ && anyLive;
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgQ[g] <= '0;
      else if (stb.cfgWr && (stb.cfgIdx == CFG_IDX_W'(g)))
        cfgQ[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      RD_CMD: begin
        rdata[BIT_INIT]               = initQ;
        rdata[BIT_START]              = startQ;
        rdata[BIT_STOP]               = stopQ;
        rdata[BIT_INTEN]              = intEnQ;
        rdata[BIT_ERRSUM]             = errSummary;
        rdata[BIT_PEND]               = anyLive;
        rdata[FLAG_LSB +: NUM_EVT]    = flagsQ;
      end
      RD_MASK: rdata[NUM_EVT-1:0] = maskQ;
      RD_CFG:  rdata = stopQ ? cfgQ[stb.cfgIdx] : '0;
      default: rdata = '0;
    endcase
  end

  assign errSummary = |flagsQ[NUM_ERR-1:0];
  assign initLevel  = initQ;
  assign startLevel = startQ;
  assign stopLevel  = stopQ;
  assign intReq     = intReqQ;

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmdWr |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ))); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (flagsQ == '0)); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (stopQ && !startQ && !initQ)); // R4
  AST_STOP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    stopQ |-> !(startQ || initQ)); // R5
  AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && !stb.cmdWr) |=> $stable(flagsQ)); // R5
  AST_CFG_GATE: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |-> stopQ); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgWr |=> $stable(cfgQ)); // R6
  AST_INT_LAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReqQ) |-> $past(intEnQ && anyLive)); // R9
endmodule

// File: rtl/csr_indirect_top.sv
module csr_indirect_top
  import csr_indirect_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ptrWr,
  input  logic                dataWr,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [DATA_W-1:0]   hostRdata,
  input  logic [NUM_EVT-1:0]  evtPulse,
  output logic                initLevel,
  output logic                startLevel,
  output logic                stopLevel,
  output logic                errSummary,
  output logic                intReq
);
  hostStb_t stb;

  csr_indirect_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ptrWr     (ptrWr),
    .dataWr    (dataWr),
    .ptrIn     (hostWdata[PTR_W-1:0]),
    .stopLevel (stopLevel),
    .stb       (stb)
  );

  csr_indirect_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (hostWdata),
    .evtPulse   (evtPulse),
    .rdata      (hostRdata),
    .initLevel  (initLevel),
    .startLevel (startLevel),
    .stopLevel  (stopLevel),
    .errSummary (errSummary),
    .intReq     (intReq)
  );
endmodule

// File: tb/tb_csr_indirect_top.sv
module tb_csr_indirect_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ptrWr = 1'b0;
  logic        dataWr = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [3:0]  evtPulse = '0;
  logic        initLevel, startLevel, stopLevel, errSummary, intReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state kept from the requirements
  bit        mStop, mStart, mInit, mIntEn;
  bit [3:0]  mFlags, mMask;
  bit [15:0] mCfg [4];

  always #10 clk = ~clk;

  csr_indirect_top dut (
    .clk(clk), .rstN(rstN), .ptrWr(ptrWr), .dataWr(dataWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .evtPulse(evtPulse),
    .initLevel(initLevel), .startLevel(startLevel), .stopLevel(stopLevel),
    .errSummary(errSummary), .intReq(intReq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] expCmd();
    bit [15:0] v = '0;
    v[0] = mInit; v[1] = mStart; v[2] = mStop; v[3] = mIntEn;
    v[6] = |mFlags[1:0];
    v[7] = |(mFlags & ~mMask);
    v[11:8] = mFlags;
    return v;
  endfunction

  function automatic bit expInt();
    return mIntEn && |(mFlags & ~mMask);
  endfunction

  function automatic bit [15:0] expRead(int p);
    if (p == 0) return expCmd();
    if (p == 1) return {12'd0, mMask};
    if (p >= 2 && p <= 5) return mStop ? mCfg[p-2] : 16'd0;
    return 16'd0;
  endfunction

  // model of one command write with an event pulse in the same cycle
  task automatic modelCmd(bit [15:0] v, bit [3:0] ev);
    bit [3:0] setM = mStop ? 4'd0 : ev;
    if (v[2]) begin
      mStop = 1; mStart = 0; mInit = 0; mFlags = '0;
    end else begin
      if (v[1] || v[0]) begin
        mStop = 0; mStart = mStart | v[1]; mInit = mInit | v[0];
      end
      mFlags = (mFlags & ~v[11:8]) | setM;
    end
    mIntEn = v[3];
  endtask

  task automatic modelData(int p, bit [15:0] v);
    if (p == 0) modelCmd(v, 4'd0);
    else if (p == 1) mMask = v[3:0];
    else if (p >= 2 && p <= 5 && mStop) mCfg[p-2] = v;
  endtask

  task automatic wrPtr(int p);
    @(negedge clk); ptrWr = 1; hostWdata = 16'(p);
    @(negedge clk); ptrWr = 0; hostWdata = '0;
  endtask

  task automatic wrData(bit [15:0] v, bit [3:0] ev = 4'd0);
    @(negedge clk); dataWr = 1; hostWdata = v; evtPulse = ev;
    @(negedge clk); dataWr = 0; hostWdata = '0; evtPulse = '0;
  endtask

  task automatic writeReg(int p, bit [15:0] v);
    wrPtr(p); wrData(v); modelData(p, v);
  endtask

  task automatic pulse(bit [3:0] ev);
    @(negedge clk); evtPulse = ev;
    @(negedge clk); evtPulse = '0;
    if (!mStop) mFlags = mFlags | ev;
  endtask

  task automatic readChk(string req, int p);
    wrPtr(p);
    chk(req, hostRdata, expRead(p));
  endtask

  task automatic idleChk(string req);
    @(negedge clk);
    chk({req, " intReq"}, {15'd0, intReq}, {15'd0, expInt()});
    chk({req, " levels"}, {12'd0, errSummary, stopLevel, startLevel, initLevel},
        {12'd0, |mFlags[1:0], mStop, mStart, mInit});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [15:0] saved;
    void'($urandom(32'd1234));
    mStop = 1; mStart = 0; mInit = 0; mIntEn = 0; mFlags = '0; mMask = '0;
    for (int i = 0; i < 4; i++) mCfg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R11 reset state, pointer starts at 0
    chk("R11 reset cmd", hostRdata, 16'h0004);
    chk("R11 reset intReq", {15'd0, intReq}, 16'd0);
    readChk("R11 reset mask", 1);
    readChk("R11 reset cfg", 3);

    // R1 / R6 configuration access while stopped
    writeReg(2, 16'hA5C3);
    chk("R1 pointer held after write", hostRdata, 16'hA5C3);
    writeReg(5, 16'h1234);
    readChk("R6 cfg written stopped", 5);
    readChk("R1 other cfg", 2);

    // R10 reserved bits of mask
    writeReg(1, 16'hFFF0);
    readChk("R10 mask reserved bits", 1);
    writeReg(1, 16'h0000);

    // R10 unimplemented pointers
    for (int p = 6; p < 16; p++) begin
      writeReg(p, 16'hFFFF);
      chk("R10 unimplemented read", hostRdata, 16'h0000);
    end
    readChk("R10 cfg untouched", 2);
    readChk("R10 cmd untouched", 0);

    // R5 events ignored while stopped
    pulse(4'hF);
    readChk("R5 stopped ignores events", 0);

    // R5 start
    writeReg(0, 16'h0002);
    idleChk("R5 start");
    readChk("R5 start readback", 0);

    // R6/R7 locked configuration while running
    writeReg(2, 16'h5555);
    chk("R7 cfg reads zero running", hostRdata, 16'h0000);
    writeReg(4, 16'hBEEF);

    // R9 interrupt lag of one cycle
    writeReg(0, 16'h0008);
    @(negedge clk); evtPulse = 4'b0100;
    @(negedge clk); evtPulse = '0; mFlags[2] = 1;
    chk("R9 intReq not yet", {15'd0, intReq}, 16'd0);
    @(negedge clk);
    chk("R9 intReq one cycle later", {15'd0, intReq}, 16'd1);
    chk("R8 no error summary", {15'd0, errSummary}, 16'd0);
    writeReg(1, 16'h0004);
    idleChk("R9 masked");
    readChk("R9 pending bit masked", 0);

    // R2 write 0 no effect, W1C clears
    writeReg(0, 16'h0008);
    readChk("R2 write zero keeps flag", 0);
    pulse(4'b0001);
    idleChk("R8 error summary");
    writeReg(0, 16'h0108);
    readChk("R2 W1C clears", 0);

    // R2 set wins over simultaneous clear
    wrPtr(0);
    wrData(16'h0208, 4'b0010);
    modelCmd(16'h0208, 4'b0010);
    chk("R2 set wins", hostRdata, expCmd());

    // R4/R3 stop wins and clears flags, same-cycle event dropped
    pulse(4'b1001);
    wrData(16'h0007, 4'b1111);
    modelCmd(16'h0007, 4'b1111);
    chk("R4 stop wins", hostRdata, 16'h0004);
    chk("R3 flags cleared", {12'd0, hostRdata[11:8]}, 16'd0);
    idleChk("R4 levels");

    // R7 value survives locked period
    readChk("R7 cfg after return to stop", 2);
    readChk("R6 running write dropped", 4);
    saved = hostRdata;
    chk("R6 cfg zero kept", saved, 16'h0000);

    // R5 init only, start untouched
    writeReg(0, 16'h0001);
    idleChk("R5 init");
    writeReg(0, 16'h0000);
    idleChk("R5 write zero keeps init");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      bit [15:0] v = 16'($urandom());
      case (op)
        0: pulse(4'($urandom()));
        1: begin
             if ($urandom_range(0, 5) != 0) v[2] = 0;
             wrPtr(0); wrData(v); modelCmd(v, 4'd0);
           end
        2: writeReg(1, v);
        3: writeReg($urandom_range(2, 7), v);
        default: readChk("R7 random cfg read", $urandom_range(2, 5));
      endcase
      idleChk("R9 random");
      readChk("R2 random cmd", 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule